// File: doc/BRIEF.md
# Protection Threshold Register Bank with Clock-Domain Crossing

This block holds three 8-bit trip levels for a battery protection unit: one for short-circuit in the discharge direction, one for discharge over-current and one for charge over-current. A processor running on a fast clock writes and reads them over a simple address bus. Each level is carried into a slow, always-running oscillator domain, where the protection comparators use it.

Every accepted write starts a per-register guard interval. A toggle request crosses into the slow domain through a two-flop synchronizer. The slow side loads its copy of the level from the CPU-side register, which is held steady, and then returns a toggle acknowledge through another two-flop synchronizer. After the acknowledge arrives, three more CPU cycles are counted before the guard ends. While a register's guard is open, further writes to that register are discarded rather than queued. A busy bit per register lets software poll for the end of the guard.

Top module: `thr_bank`

## Requirements
- R1: The short-circuit level is at address 0xF5, the discharge over-current level at 0xF6 and the charge over-current level at 0xF7. A read issued on one CPU clock returns its data on `rd_data` after that clock edge. A read of any other address returns 0x00, and a write to any other address changes nothing.
- R2: After reset, all three registers read 0xF3, all three `lvl_o` fields are 0xF3, and all `busy` bits are 0.
- R3: A write that is accepted is visible to a read issued on the next CPU cycle. This holds while the guard is still open and before the value has reached the slow domain.
- R4: `busy[i]` rises on the CPU edge that accepts a write to register i. With the slow clock at one eighth of the CPU rate, it stays high for at least 27 CPU cycles, which is 3 slow periods plus 3 CPU cycles.
- R5: A write to a register whose busy bit is 1 at the clock edge is dropped, and the stored value stays unchanged.
- R6: The guards are independent. A register is not locked by writes to the other registers. Busy bit 0 belongs to 0xF5, bit 1 to 0xF6 and bit 2 to 0xF7.
- R7: `lvl_o[i]` shows only the last level to have crossed or the newly accepted value. It holds the accepted value by the time `busy[i]` falls.
- R8: With the 8:1 clock ratio, `busy[i]` falls no later than 50 CPU cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Fast CPU-side clock |
| cpu_rst | input | 1 | Synchronous active-high reset, CPU domain |
| slow_clk | input | 1 | Slow always-on oscillator clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| addr | input | 8 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| busy | output | 3 | Guard-open flag per register |
| lvl_o | output | 3x8 | Levels in the slow domain, index 0 = short-circuit |

## Verification
Read data is due one CPU edge after the read strobe. A busy bit is due high at the accepting edge. It must then stay high through every sample up to 27 cycles later and fall by cycle 50. At the falling edge of busy, the slow copy must already hold the accepted value. A behavioural model updates at every CPU falling edge, after the design's registers have settled from the rising edge. It decides from its own lock state whether each write is accepted, and it checks the read data, each busy bit's age window and the allowed values of each level on that same cycle.

// File: rtl/thr_pkg.sv
package thr_pkg;
  parameter int unsigned LVL_W = 8;
  parameter logic [LVL_W-1:0] LVL_RST = 8'hF3;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/thr_sync.sv
module thr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/thr_chan.sv
module thr_chan
  import thr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TAIL_CYC    = 3
) (
  input  logic cpu_clk,
  input  logic cpu_rst,
  input  logic slow_clk,
  input  logic slow_rst,
  input  logic wr_hit,
  input  lvl_t wr_data,
  output lvl_t value,
  output logic busy,
  output lvl_t level
);
  localparam int CNT_W = (TAIL_CYC > 1) ? $clog2(TAIL_CYC) : 1;

  // CPU side
  lvl_t             shadow_q;
  logic             busy_q, acked_q, req_q, ack_s;
  logic [CNT_W-1:0] tail_q;

  // Slow side
  logic req_s, seen_q, ack_q;
  lvl_t level_q;

  always_ff @(posedge cpu_clk) begin
    if (cpu_rst) begin
      shadow_q <= LVL_RST;
      busy_q   <= 1'b0;
      acked_q  <= 1'b0;
      req_q    <= 1'b0;
      tail_q   <= '0;
    end else if (wr_hit && !busy_q) begin
      shadow_q <= wr_data;
      req_q    <= ~req_q;
      busy_q   <= 1'b1;
      acked_q  <= 1'b0;
      tail_q   <= '0;
    end else if (busy_q) begin
      if (!acked_q) begin
        if (ack_s == req_q) acked_q <= 1'b1;
      end else if (tail_q == CNT_W'(TAIL_CYC - 1)) begin
        busy_q <= 1'b0;
      end else begin
        tail_q <= tail_q + 1'b1;
      end
    end
  end

  thr_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(slow_clk), .rst(slow_rst), .d(req_q), .q(req_s)
  );

  thr_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(cpu_clk), .rst(cpu_rst), .d(ack_q), .q(ack_s)
  );

  // Load on a detected request toggle; acknowledge one slow cycle later.
  always_ff @(posedge slow_clk) begin
    if (slow_rst) begin
      seen_q  <= 1'b0;
      ack_q   <= 1'b0;
      level_q <= LVL_RST;
    end else begin
      seen_q <= req_s;
      ack_q  <= seen_q;
      if (req_s != seen_q) level_q <= shadow_q;
    end
  end

  assign value = shadow_q;
  assign busy  = busy_q;
  assign level = level_q;

  AST_LOCKED_HOLD: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    busy_q |=> $stable(shadow_q)); // R5
  AST_BUSY_ON_ACCEPT: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    (wr_hit && !busy_q) |=> busy_q); // R4
  AST_RELEASE_AFTER_ACK: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    $fell(busy_q) |-> (ack_s == req_q)); // R4
  AST_LEVEL_QUIET: assert property (@(posedge slow_clk) disable iff (slow_rst)
    (req_s == seen_q) |=> $stable(level_q)); // R7
endmodule

// File: rtl/thr_bank.sv
module thr_bank
  import thr_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int unsigned BASE_ADDR   = 'hF5,
  parameter int          N_REG       = 3,
  parameter int          SYNC_STAGES = 2,
  parameter int          TAIL_CYC    = 3
) (
  input  logic                         cpu_clk,
  input  logic                         cpu_rst,
  input  logic                         slow_clk,
  input  logic                         slow_rst,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         wr_en,
  input  logic [LVL_W-1:0]             wr_data,
  input  logic                         rd_en,
  output logic [LVL_W-1:0]             rd_data,
  output logic [N_REG-1:0]             busy,
  output logic [N_REG-1:0][LVL_W-1:0]  lvl_o
);
  logic [N_REG-1:0] sel;
  lvl_t             vals [N_REG];
  lvl_t             rd_mux;
  logic             in_range;

  for (genvar i = 0; i < N_REG; i++) begin : g_chan
    assign sel[i] = (addr == ADDR_W'(BASE_ADDR + i));

    thr_chan #(.SYNC_STAGES(SYNC_STAGES), .TAIL_CYC(TAIL_CYC)) u_chan (
      .cpu_clk (cpu_clk),
      .cpu_rst (cpu_rst),
      .slow_clk(slow_clk),
      .slow_rst(slow_rst),
      .wr_hit  (wr_en && sel[i]),
      .wr_data (wr_data),
      .value   (vals[i]),
      .busy    (busy[i]),
      .level   (lvl_o[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_REG; i++)
      if (sel[i]) rd_mux = vals[i];
  end

  assign in_range = |sel;

  always_ff @(posedge cpu_clk) begin
    if (cpu_rst)    rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  AST_RD_OUTSIDE: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    (rd_en && !in_range) |=> (rd_data == '0)); // R1
endmodule

// File: tb/thr_bank_tb_top.sv
`timescale 1ns/1ps
module thr_bank_tb_top;
  localparam int MIN_HOLD = 27;
  localparam int MAX_HOLD = 50;

  logic cpu_clk = 0, slow_clk = 0;
  logic cpu_rst = 1, slow_rst = 1;
  logic [7:0] addr = 0, wr_data = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] rd_data;
  logic [2:0] busy;
  logic [2:0][7:0] lvl_o;

  int checks = 0, failures = 0, wd = 0;
  bit run = 0;

  logic [7:0] mval [3];
  logic [7:0] committed [3];
  bit         lock [3];
  int         age [3];
  logic       s_wr, s_rd;
  logic [7:0] s_addr, s_data;

  thr_bank dut_i (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .busy(busy), .lvl_o(lvl_o)
  );

  always #2.5 cpu_clk = ~cpu_clk;
  initial begin
    #7;
    forever #20 slow_clk = ~slow_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge cpu_clk) begin
    s_wr   <= wr_en;
    s_rd   <= rd_en;
    s_addr <= addr;
    s_data <= wr_data;
  end

  // Reference model, updated after each rising edge has settled.
  always @(negedge cpu_clk) begin
    if (run && !cpu_rst) begin
      if (s_rd) begin
        if (s_addr >= 8'hF5 && s_addr <= 8'hF7)
          chk(rd_data == mval[s_addr - 8'hF5], "R3", rd_data, mval[s_addr - 8'hF5]);
        else
          chk(rd_data == 8'h00, "R1", rd_data, 0);
      end
      for (int i = 0; i < 3; i++) begin
        if (s_wr && s_addr == 8'hF5 + i[7:0] && !lock[i]) begin
          mval[i] = s_data;
          lock[i] = 1;
          age[i]  = 0;
        end
        if (lock[i]) begin
          age[i]++;
          if (!busy[i]) begin
            chk(age[i] >= MIN_HOLD, "R4", age[i], MIN_HOLD);
            chk(lvl_o[i] == mval[i], "R7", lvl_o[i], mval[i]);
            committed[i] = mval[i];
            lock[i] = 0;
          end else if (age[i] > MAX_HOLD) begin
            chk(0, "R8", age[i], MAX_HOLD);
            committed[i] = mval[i];
            lock[i] = 0;
          end
        end else begin
          chk(busy[i] == 1'b0, "R4", busy[i], 0);
        end
        chk(lvl_o[i] == committed[i] || lvl_o[i] == mval[i], "R7", lvl_o[i], mval[i]);
      end
    end
  end

  task automatic cyc(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d);
    @(negedge cpu_clk);
    #1;
    wr_en = w; rd_en = r; addr = a; wr_data = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 8'h00, 8'h00);
  endtask

  always @(posedge cpu_clk) begin
    wd++;
    if (wd > 100000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", wd, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      mval[i] = 8'hF3; committed[i] = 8'hF3; lock[i] = 0; age[i] = 0;
    end
    repeat (20) @(posedge cpu_clk);
    @(negedge cpu_clk);
    cpu_rst = 0; slow_rst = 0;
    run = 1;
    // R2: reset state
    chk(busy == 3'b000, "R2", busy, 0);
    for (int i = 0; i < 3; i++) chk(lvl_o[i] == 8'hF3, "R2", lvl_o[i], 8'hF3);
    cyc(0, 1, 8'hF5, 0);
    @(negedge cpu_clk);
    chk(rd_data == 8'hF3, "R2", rd_data, 8'hF3);
    cyc(0, 1, 8'hF6, 0);
    cyc(0, 1, 8'hF7, 0);
    // R5/R6: locked write dropped, other register still free
    cyc(1, 0, 8'hF5, 8'h12);
    cyc(1, 0, 8'hF5, 8'h34);
    cyc(1, 1, 8'hF6, 8'h56);
    cyc(0, 1, 8'hF5, 0);
    @(negedge cpu_clk);
    chk(busy[1] == 1'b1, "R6", busy[1], 1);
    chk(rd_data == 8'h12, "R5", rd_data, 8'h12);
    idle(60);
    for (int a = 'hF4; a <= 'hF8; a++) cyc(0, 1, a[7:0], 0);
    // Patterns on the charge register
    cyc(1, 0, 8'hF7, 8'h00); idle(55);
    cyc(1, 0, 8'hF7, 8'hFF); idle(55);
    cyc(1, 1, 8'hF7, 8'hA5); cyc(0, 1, 8'hF7, 0); idle(55);
    // R1: outside writes ignored
    cyc(1, 0, 8'hF4, 8'h11);
    cyc(1, 0, 8'hF8, 8'h22);
    cyc(1, 0, 8'h00, 8'h33);
    for (int a = 'hF4; a <= 'hF8; a++) cyc(0, 1, a[7:0], 0);
    idle(5);
    // Hammer all three registers
    for (int k = 0; k < 150; k++) begin
      cyc(1, 1, 8'hF5 + 8'(k % 3), 8'(k * 7 + 3));
    end
    idle(60);
    for (int a = 'hF5; a <= 'hF7; a++) cyc(0, 1, a[7:0], 0);
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule